// File: doc/BRIEF.md
# Debug Watchpoint Output Generator

This block turns single-cycle debug events into a vector of registered watchpoint pulses that external monitoring or trace logic can observe. The events come from instruction-address comparators, data-address comparators and debug-counter events that sit outside this block. A watchpoint fires whenever its event fires. The per-event status enables do not gate it, and neither does the debug-interrupt enable. It is produced only while a debug mode is selected, and it is held off while a debug session is active.

Next to the watchpoint path, the block produces a status-set request for each event. A request is raised only when that event's own enable bit is set. The two paths use the same event vector and the same one-cycle register stage, so an event and its watchpoint stay aligned for any downstream logic that correlates them.

Top module: `dbg_watchpoint_gen`

## Requirements
- R1: While `rst` is high at a rising clock edge, both `wpt_o` and `stat_req_o` are all zero after that edge. This holds regardless of any other input.
- R2: With the defaults, `wpt_o` bits 0..3 follow instruction compares 1..4 (`iac_hit[0..3]`), bit 4 follows `dac_hit[0]`, bit 5 follows `dac_hit[1]`, bit 6 follows `cnt_hit[0]` and bit 7 follows `cnt_hit[1]`.
- R3: A watchpoint bit is high in the clock cycle after its event is high. It is high for exactly one cycle for each cycle in which the event is high.
- R4: Watchpoints are produced only when `mode_int` or `mode_ext` is 1. When both are 0, `wpt_o` is zero one cycle later.
- R5: While `sess_active` is 1, `wpt_o` is zero one cycle later, in either debug mode.
- R6: `stat_en` has no effect on `wpt_o`. An event whose enable bit is 0 still produces its watchpoint.
- R7: `dbg_irq_en` has no effect on `wpt_o` or on `stat_req_o`.
- R8: `stat_req_o[i]` is high in the cycle after event `i` is high while `stat_en[i]` is 1. Event `i` uses the bit numbering of R2. This output does not depend on the debug-mode inputs or on `sess_active`.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| iac_hit | input | 4 | Instruction-address compare events, compare 1 at bit 0 |
| dac_hit | input | 2 | Data-address compare events, compare 1 at bit 0 |
| cnt_hit | input | 2 | Debug-counter events, counter 1 at bit 0 |
| mode_int | input | 1 | Internal debug mode selected |
| mode_ext | input | 1 | External debug mode selected |
| sess_active | input | 1 | Debug session in progress, suppresses watchpoints |
| dbg_irq_en | input | 1 | Debug-interrupt enable, no influence on outputs |
| stat_en | input | 8 | Per-event status-set enables |
| wpt_o | output | 8 | Registered watchpoint pulses |
| stat_req_o | output | 8 | Registered status-set requests |

## Verification
The bench runs through all 256 event patterns for every combination of the two mode bits, the session flag and the interrupt enable. On each vector it changes the status-enable word as well. Because of this sweep, a swapped bit position shows up apart from a gate that uses the wrong mode term or ignores the session flag. It also shows up apart from a watchpoint path that has picked up the status enables by mistake. Directed sequences add a single isolated event followed by idle, to show that the pulse is exactly one cycle long. They also add a reset asserted while every event is active, and an interrupt-enable toggle with all other inputs held.

// File: rtl/wpt_pkg.sv
package wpt_pkg;
  // Default event-source counts
  localparam int unsigned IAC_DEF = 4;
  localparam int unsigned DAC_DEF = 2;
  localparam int unsigned CNT_DEF = 2;

  // Bit offset of each source group inside the merged event vector
  function automatic int unsigned dac_base(input int unsigned n_iac);
    return n_iac;
  endfunction

  function automatic int unsigned cnt_base(input int unsigned n_iac, input int unsigned n_dac);
    return n_iac + n_dac;
  endfunction

  typedef enum logic [1:0] {
    GATE_CLOSED  = 2'b00,
    GATE_OPEN    = 2'b01,
    GATE_SESSION = 2'b10
  } gate_state_e;
endpackage

// File: rtl/wpt_event_merge.sv
module wpt_event_merge #(
  parameter int unsigned IAC_N = 4,
  parameter int unsigned DAC_N = 2,
  parameter int unsigned CNT_N = 2,
  localparam int unsigned EVT_W = IAC_N + DAC_N + CNT_N
) (
  input  logic [IAC_N-1:0] iac_hit,
  input  logic [DAC_N-1:0] dac_hit,
  input  logic [CNT_N-1:0] cnt_hit,
  output logic [EVT_W-1:0] evt_vec
);
  import wpt_pkg::*;
  localparam int unsigned DAC_OFS = dac_base(IAC_N);
  localparam int unsigned CNT_OFS = cnt_base(IAC_N, DAC_N);

  // The position of each event fixes which watchpoint line it drives
  for (genvar gi = 0; gi < IAC_N; gi++) begin : g_iac
    assign evt_vec[gi] = iac_hit[gi];
  end
  for (genvar gd = 0; gd < DAC_N; gd++) begin : g_dac
    assign evt_vec[DAC_OFS + gd] = dac_hit[gd];
  end
  for (genvar gc = 0; gc < CNT_N; gc++) begin : g_cnt
    assign evt_vec[CNT_OFS + gc] = cnt_hit[gc];
  end
endmodule

// File: rtl/wpt_gate_reg.sv
module wpt_gate_reg #(
  parameter int unsigned W = 8
) (
  input  logic         clk,
  input  logic         rst,
  input  logic [W-1:0] evt_vec,
  input  logic         mode_int,
  input  logic         mode_ext,
  input  logic         sess_active,
  output logic [W-1:0] wpt_q
);
  import wpt_pkg::*;
  gate_state_e gate;

  always_comb begin
    if (!(mode_int || mode_ext)) gate = GATE_CLOSED;
    else if (sess_active)        gate = GATE_SESSION;
    else                         gate = GATE_OPEN;
  end

  always_ff @(posedge clk) begin
    if (rst) begin
      wpt_q <= '0;
    end else if (gate == GATE_OPEN) begin
      wpt_q <= evt_vec;
    end else begin
      wpt_q <= '0;
    end
  end
endmodule

// File: rtl/wpt_status_reg.sv
module wpt_status_reg #(
  parameter int unsigned W = 8
) (
  input  logic         clk,
  input  logic         rst,
  input  logic [W-1:0] evt_vec,
  input  logic [W-1:0] stat_en,
  output logic [W-1:0] req_q
);
  always_ff @(posedge clk) begin
    if (rst) req_q <= '0;
    else     req_q <= evt_vec & stat_en;
  end
endmodule

// File: rtl/dbg_watchpoint_gen.sv
module dbg_watchpoint_gen #(
  parameter int unsigned IAC_N = wpt_pkg::IAC_DEF,
  parameter int unsigned DAC_N = wpt_pkg::DAC_DEF,
  parameter int unsigned CNT_N = wpt_pkg::CNT_DEF,
  localparam int unsigned WPT_W = IAC_N + DAC_N + CNT_N
) (
  input  logic             clk,
  input  logic             rst,
  input  logic [IAC_N-1:0] iac_hit,
  input  logic [DAC_N-1:0] dac_hit,
  input  logic [CNT_N-1:0] cnt_hit,
  input  logic             mode_int,
  input  logic             mode_ext,
  input  logic             sess_active,
  input  logic             dbg_irq_en,
  input  logic [WPT_W-1:0] stat_en,
  output logic [WPT_W-1:0] wpt_o,
  output logic [WPT_W-1:0] stat_req_o
);
  logic [WPT_W-1:0] evt_vec;
  // Interrupt enable deliberately plays no part in either path
  logic irq_en_unused;
  assign irq_en_unused = dbg_irq_en;

  wpt_event_merge #(.IAC_N(IAC_N), .DAC_N(DAC_N), .CNT_N(CNT_N)) i_merge (
    .iac_hit (iac_hit),
    .dac_hit (dac_hit),
    .cnt_hit (cnt_hit),
    .evt_vec (evt_vec)
  );

  wpt_gate_reg #(.W(WPT_W)) i_gate (
    .clk         (clk),
    .rst         (rst),
    .evt_vec     (evt_vec),
    .mode_int    (mode_int),
    .mode_ext    (mode_ext),
    .sess_active (sess_active),
    .wpt_q       (wpt_o)
  );

  wpt_status_reg #(.W(WPT_W)) i_stat (
    .clk     (clk),
    .rst     (rst),
    .evt_vec (evt_vec),
    .stat_en (stat_en),
    .req_q   (stat_req_o)
  );
endmodule

// File: rtl/wpt_checker.sv
module wpt_checker #(
  parameter int unsigned IAC_N = 4,
  parameter int unsigned DAC_N = 2,
  parameter int unsigned CNT_N = 2,
  localparam int unsigned W = IAC_N + DAC_N + CNT_N
) (
  input logic             clk,
  input logic             rst,
  input logic [IAC_N-1:0] iac_hit,
  input logic [DAC_N-1:0] dac_hit,
  input logic [CNT_N-1:0] cnt_hit,
  input logic             mode_int,
  input logic             mode_ext,
  input logic             sess_active,
  input logic [W-1:0]     stat_en,
  input logic [W-1:0]     wpt_o,
  input logic [W-1:0]     stat_req_o
);
  logic [W-1:0] ev;
  assign ev = {cnt_hit, dac_hit, iac_hit};

  // R1
  a_r1_reset_clears: assert property (@(posedge clk)
    rst |=> (wpt_o == '0 && stat_req_o == '0));
  // R4
  a_r4_mode_off_quiet: assert property (@(posedge clk) disable iff (rst)
    !(mode_int || mode_ext) |=> wpt_o == '0);
  // R5
  a_r5_session_quiet: assert property (@(posedge clk) disable iff (rst)
    sess_active |=> wpt_o == '0);
  // R2, R3, R6
  a_r3_follows_event: assert property (@(posedge clk) disable iff (rst)
    ((mode_int || mode_ext) && !sess_active) |=> wpt_o == $past(ev));
  // R8
  a_r8_status_req: assert property (@(posedge clk) disable iff (rst)
    1'b1 |=> stat_req_o == $past(ev & stat_en));
endmodule

bind dbg_watchpoint_gen wpt_checker #(.IAC_N(IAC_N), .DAC_N(DAC_N), .CNT_N(CNT_N)) i_chk (
  .clk         (clk),
  .rst         (rst),
  .iac_hit     (iac_hit),
  .dac_hit     (dac_hit),
  .cnt_hit     (cnt_hit),
  .mode_int    (mode_int),
  .mode_ext    (mode_ext),
  .sess_active (sess_active),
  .stat_en     (stat_en),
  .wpt_o       (wpt_o),
  .stat_req_o  (stat_req_o)
);

// File: tb/test_dbg_watchpoint_gen.sv
`timescale 1ns/1ps
module test_dbg_watchpoint_gen;
  logic       clk = 1'b0;
  logic       rst = 1'b1;
  logic [3:0] iac_hit = '0;
  logic [1:0] dac_hit = '0;
  logic [1:0] cnt_hit = '0;
  logic       mode_int = 1'b0, mode_ext = 1'b0, sess_active = 1'b0, dbg_irq_en = 1'b0;
  logic [7:0] stat_en = '0;
  logic [7:0] wpt_o, stat_req_o;

  int n_cmp = 0;
  int n_bad = 0;
  bit done = 1'b0;

  always #4 clk = ~clk;  // 125 MHz

  dbg_watchpoint_gen i_dbg_watchpoint_gen (
    .clk(clk), .rst(rst), .iac_hit(iac_hit), .dac_hit(dac_hit), .cnt_hit(cnt_hit),
    .mode_int(mode_int), .mode_ext(mode_ext), .sess_active(sess_active),
    .dbg_irq_en(dbg_irq_en), .stat_en(stat_en), .wpt_o(wpt_o), .stat_req_o(stat_req_o)
  );

  task automatic check(input string req, input logic [7:0] act, input logic [7:0] exp);
    n_cmp++;
    if (act !== exp) begin
      n_bad++;
      $display("FAIL %s: actual %02h expected %02h at %0t", req, act, exp, $time);
    end
  endtask

  // Drive inputs on the falling edge; the result is visible at the next falling edge
  task automatic apply(input logic [7:0] ev, input logic mi, input logic me,
                       input logic s, input logic irq, input logic [7:0] en);
    iac_hit = ev[3:0]; dac_hit = ev[5:4]; cnt_hit = ev[7:6];
    mode_int = mi; mode_ext = me; sess_active = s; dbg_irq_en = irq; stat_en = en;
    @(posedge clk);
    @(negedge clk);
  endtask

  task automatic finish_run();
    $display("  *** SUMMARY: %0d compared / %0d mismatched ***", n_cmp, n_bad);
    $finish;
  endtask

  initial begin
    repeat (3) @(posedge clk);
    @(negedge clk);
    check("R1 reset wpt", wpt_o, 8'h00);
    check("R1 reset req", stat_req_o, 8'h00);
    rst = 1'b0;

    // Exhaustive sweep: events x modes x session x irq enable
    for (int ctl = 0; ctl < 16; ctl++) begin
      for (int p = 0; p < 256; p++) begin
        logic mi, me, s, irq;
        logic [7:0] ev, en, exp_w;
        mi = ctl[0]; me = ctl[1]; s = ctl[2]; irq = ctl[3];
        ev = 8'(p);
        en = 8'(p * 37 + ctl * 11) ^ 8'h5A;
        apply(ev, mi, me, s, irq, en);
        exp_w = ((mi | me) && !s) ? ev : 8'h00;
        if (!(mi | me))  check("R4 mode off", wpt_o, exp_w);
        else if (s)      check("R5 session", wpt_o, exp_w);
        else             check("R2 mapping", wpt_o, exp_w);
        check("R8 status req", stat_req_o, ev & en);
      end
    end

    // R3: an isolated event gives a single-cycle pulse
    apply(8'h10, 1'b1, 1'b0, 1'b0, 1'b0, 8'h00);
    check("R3 pulse high", wpt_o, 8'h10);
    apply(8'h00, 1'b1, 1'b0, 1'b0, 1'b0, 8'h00);
    check("R3 pulse low", wpt_o, 8'h00);
    apply(8'h80, 1'b0, 1'b1, 1'b0, 1'b0, 8'h00);
    check("R3 pulse ext", wpt_o, 8'h80);
    apply(8'h00, 1'b0, 1'b1, 1'b0, 1'b0, 8'h00);
    check("R3 pulse ext low", wpt_o, 8'h00);

    // R6: enables all zero, watchpoints still fire
    apply(8'hFF, 1'b1, 1'b1, 1'b0, 1'b0, 8'h00);
    check("R6 enables ignored", wpt_o, 8'hFF);
    check("R6 no requests", stat_req_o, 8'h00);

    // R7: toggling interrupt enable changes nothing
    apply(8'hA5, 1'b1, 1'b0, 1'b0, 1'b0, 8'h0F);
    check("R7 irq0 wpt", wpt_o, 8'hA5);
    check("R7 irq0 req", stat_req_o, 8'h05);
    apply(8'hA5, 1'b1, 1'b0, 1'b0, 1'b1, 8'h0F);
    check("R7 irq1 wpt", wpt_o, 8'hA5);
    check("R7 irq1 req", stat_req_o, 8'h05);

    // R1: reset wins over active events
    rst = 1'b1;
    apply(8'hFF, 1'b1, 1'b1, 1'b0, 1'b1, 8'hFF);
    check("R1 mid reset wpt", wpt_o, 8'h00);
    check("R1 mid reset req", stat_req_o, 8'h00);
    rst = 1'b0;
    apply(8'h3C, 1'b1, 1'b0, 1'b0, 1'b0, 8'hFF);
    check("R2 after reset", wpt_o, 8'h3C);

    done = 1'b1;
    finish_run();
  end

  initial begin
    #(200000 * 8);
    if (!done) begin
      n_cmp++;
      n_bad++;
      $display("FAIL watchdog: actual hung expected finished");
      finish_run();
    end
  end
endmodule